// File: doc/BRIEF.md
# Lane Local-Store Bridge

This block sits between a single 32-bit main-memory port and a group of lock-step processing lanes. It keeps one local-store slot per lane. Moving data between memory and the slots is serial: each memory operation touches one slot and one memory word. Moving data between the slots and the lanes' register files happens in one step for all lanes at once. Two operations fan data out. A wide fetch copies one memory word into every slot. A fan-out copies one chosen slot into the same register of every lane, so lanes can exchange values without a round trip through memory.

Indexed accesses take their memory address from the index address that one chosen lane has computed, so per-lane addresses are served one lane at a time. A memory read returns its data one cycle after the request. While a memory operation is in flight the bridge raises `busy` and does not take new operations. The register side completes in a single cycle and never raises `busy`.

Top module: `lane_ls_bridge`

## Requirements
- R1: After reset, `busy`, `mem_req` and `reg_wr_en` are low and every slot holds zero.
- R2: An operation is taken at a rising edge only when `op_valid` is high and `busy` is low. An operation presented while `busy` is high changes neither the slots, the memory port nor the register outputs.
- R3: Fetch (`op_code` 1) issues a read of `op_addr` and writes the returned word into slot `op_lane`. `busy` is high for exactly two cycles.
- R4: Spill (`op_code` 2) issues a write of slot `op_lane` to `op_addr`. `busy` is high for exactly one cycle.
- R5: Fetch-all (`op_code` 3) reads `op_addr` once and writes that word into every slot.
- R6: To-regs (`op_code` 6) drives `reg_wr_en` all ones for the one cycle after acceptance, with `reg_wr_idx` = `op_reg` and lane i of `reg_wr_data` (bits i*32 upward) = slot i.
- R7: From-regs (`op_code` 8 is fan-out, 7 is from-regs) loads slot i from lane i of `lane_rd_data`, sampled in the acceptance cycle, and leaves `busy` low.
- R8: Fan-out (`op_code` 8) drives `reg_wr_en` all ones for one cycle, with every lane of `reg_wr_data` equal to slot `op_lane`.
- R9: Indexed fetch (`op_code` 4) and indexed spill (`op_code` 5) use lane `op_lane` of `lane_addr` (bits lane*14 upward) as the memory address. Otherwise they behave as R3 and R4.
- R10: Only one memory request is made per operation. `mem_req` is a single-cycle pulse in the cycle after acceptance, with `mem_we` high for spills and low for fetches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present |
| op_code | input | 4 | Operation code |
| op_lane | input | 2 | Selected lane / slot |
| op_addr | input | 14 | Direct memory address |
| op_reg | input | 5 | Register index for lane writes |
| lane_addr | input | 56 | Per-lane index addresses, packed |
| lane_rd_data | input | 128 | Per-lane register read data, packed |
| busy | output | 1 | Memory operation in flight |
| mem_req | output | 1 | Memory request strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 14 | Memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after request |
| reg_wr_en | output | 4 | Per-lane register write strobe |
| reg_wr_idx | output | 5 | Register index to write |
| reg_wr_data | output | 128 | Per-lane register write data, packed |

## Verification
The bench builds the bridge with its defaults: four lanes, 32-bit data, 14-bit addresses and slots cleared on reset. Four lanes with distinct register and index-address patterns make any lane swap, wrong slot select or stuck fan-out source visible in the packed outputs. The bench memory model answers with the one-cycle read latency, so the two-cycle and one-cycle busy windows can be counted exactly. It also reaches the case where an operation is held on the inputs during those windows.

// File: rtl/lsb_pkg.sv
package lsb_pkg;

   typedef enum logic [3:0] {
      OP_IDLE      = 4'd0,
      OP_FETCH     = 4'd1,
      OP_SPILL     = 4'd2,
      OP_FETCH_ALL = 4'd3,
      OP_FETCH_IX  = 4'd4,
      OP_SPILL_IX  = 4'd5,
      OP_TO_REGS   = 4'd6,
      OP_FROM_REGS = 4'd7,
      OP_FANOUT    = 4'd8
   } lsb_op_e;

   typedef enum logic [1:0] {
      MP_IDLE = 2'd0,
      MP_REQ  = 2'd1,
      MP_WAIT = 2'd2
   } mp_state_e;

   function automatic logic op_uses_mem(lsb_op_e o);
      return (o == OP_FETCH) || (o == OP_SPILL) || (o == OP_FETCH_ALL) ||
             (o == OP_FETCH_IX) || (o == OP_SPILL_IX);
   endfunction

   function automatic logic op_writes_mem(lsb_op_e o);
      return (o == OP_SPILL) || (o == OP_SPILL_IX);
   endfunction

   function automatic logic op_indexed(lsb_op_e o);
      return (o == OP_FETCH_IX) || (o == OP_SPILL_IX);
   endfunction

endpackage

// File: rtl/lsb_mem_port.sv
module lsb_mem_port
   import lsb_pkg::*;
#(
   parameter int LANES  = 4,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 14,
   localparam int LANE_W = $clog2(LANES)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      accept,
   input  lsb_op_e                   op,
   input  logic [LANE_W-1:0]         op_lane,
   input  logic [ADDR_W-1:0]         op_addr,
   input  logic [LANES*ADDR_W-1:0]   lane_addr,
   input  logic [DATA_W-1:0]         sel_data,
   output logic                      busy,
   output logic                      mem_req,
   output logic                      mem_we,
   output logic [ADDR_W-1:0]         mem_addr,
   output logic [DATA_W-1:0]         mem_wdata,
   output logic                      fill_valid,
   output logic                      fill_wide,
   output logic [LANE_W-1:0]         fill_lane
);

   mp_state_e         state_q;
   logic [ADDR_W-1:0] ix_addr;

   assign ix_addr    = lane_addr[op_lane*ADDR_W +: ADDR_W];
   assign busy       = (state_q != MP_IDLE);
   assign fill_valid = (state_q == MP_WAIT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= MP_IDLE;
         mem_req   <= 1'b0;
         mem_we    <= 1'b0;
         mem_addr  <= '0;
         mem_wdata <= '0;
         fill_wide <= 1'b0;
         fill_lane <= '0;
      end else begin
         case (state_q)
            MP_IDLE: begin
               if (accept && op_uses_mem(op)) begin
                  mem_req   <= 1'b1;
                  mem_we    <= op_writes_mem(op);
                  mem_addr  <= op_indexed(op) ? ix_addr : op_addr;
                  mem_wdata <= sel_data;
                  fill_wide <= (op == OP_FETCH_ALL);
                  fill_lane <= op_lane;
                  state_q   <= MP_REQ;
               end
            end
            MP_REQ: begin
               mem_req <= 1'b0;
               state_q <= mem_we ? MP_IDLE : MP_WAIT;
            end
            default: state_q <= MP_IDLE;
         endcase
      end
   end

   p_req_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);
   p_req_in_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> busy);
   p_read_holds_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |=> (busy && fill_valid));
   p_write_frees_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |=> !busy);

endmodule

// File: rtl/lsb_slot_bank.sv
module lsb_slot_bank #(
   parameter int LANES       = 4,
   parameter int DATA_W      = 32,
   parameter bit CLEAR_SLOTS = 1'b1,
   localparam int LANE_W = $clog2(LANES)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      fill_valid,
   input  logic                      fill_wide,
   input  logic [LANE_W-1:0]         fill_lane,
   input  logic [DATA_W-1:0]         mem_rdata,
   input  logic                      load_regs,
   input  logic [LANES*DATA_W-1:0]   lane_rd_data,
   input  logic [LANE_W-1:0]         rd_lane,
   output logic [LANES*DATA_W-1:0]   slots,
   output logic [DATA_W-1:0]         sel_data
);

   for (genvar i = 0; i < LANES; i++) begin : g_slot
      logic [DATA_W-1:0] slot_q;
      logic [DATA_W-1:0] nxt;
      logic              upd;

      always_comb begin
         upd = 1'b0;
         nxt = slot_q;
         if (fill_valid && (fill_wide || fill_lane == LANE_W'(i))) begin
            upd = 1'b1;
            nxt = mem_rdata;
         end else if (load_regs) begin
            upd = 1'b1;
            nxt = lane_rd_data[i*DATA_W +: DATA_W];
         end
      end

      if (CLEAR_SLOTS) begin : g_clr
         always_ff @(posedge clk) begin
            if (!rst_n)   slot_q <= '0;
            else if (upd) slot_q <= nxt;
         end
      end else begin : g_keep
         always_ff @(posedge clk) begin
            if (upd) slot_q <= nxt;
         end
      end

      assign slots[i*DATA_W +: DATA_W] = slot_q;
   end

   assign sel_data = slots[rd_lane*DATA_W +: DATA_W];

   p_fill_excl_regs_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(fill_valid && load_regs));
   p_wide_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_valid && fill_wide) |=>
         (slots[0 +: DATA_W] == slots[(LANES-1)*DATA_W +: DATA_W]));

endmodule

// File: rtl/lsb_lane_xfer.sv
module lsb_lane_xfer
   import lsb_pkg::*;
#(
   parameter int LANES  = 4,
   parameter int DATA_W = 32,
   parameter int REG_W  = 5
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      accept,
   input  lsb_op_e                   op,
   input  logic [REG_W-1:0]          op_reg,
   input  logic [LANES*DATA_W-1:0]   slots,
   input  logic [DATA_W-1:0]         sel_data,
   output logic [LANES-1:0]          reg_wr_en,
   output logic [REG_W-1:0]          reg_wr_idx,
   output logic [LANES*DATA_W-1:0]   reg_wr_data
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reg_wr_en   <= '0;
         reg_wr_idx  <= '0;
         reg_wr_data <= '0;
      end else begin
         reg_wr_en <= '0;
         if (accept && op == OP_TO_REGS) begin
            reg_wr_en   <= '1;
            reg_wr_idx  <= op_reg;
            reg_wr_data <= slots;
         end else if (accept && op == OP_FANOUT) begin
            reg_wr_en   <= '1;
            reg_wr_idx  <= op_reg;
            reg_wr_data <= {LANES{sel_data}};
         end
      end
   end

   p_wr_idx_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && (op == OP_TO_REGS || op == OP_FANOUT)) |=>
         (reg_wr_idx == $past(op_reg)));

endmodule

// File: rtl/lane_ls_bridge.sv
module lane_ls_bridge
   import lsb_pkg::*;
#(
   parameter int LANES       = 4,
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 14,
   parameter int REG_W       = 5,
   parameter bit CLEAR_SLOTS = 1'b1,
   localparam int LANE_W = $clog2(LANES)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      op_valid,
   input  logic [3:0]                op_code,
   input  logic [LANE_W-1:0]         op_lane,
   input  logic [ADDR_W-1:0]         op_addr,
   input  logic [REG_W-1:0]          op_reg,
   input  logic [LANES*ADDR_W-1:0]   lane_addr,
   input  logic [LANES*DATA_W-1:0]   lane_rd_data,
   output logic                      busy,
   output logic                      mem_req,
   output logic                      mem_we,
   output logic [ADDR_W-1:0]         mem_addr,
   output logic [DATA_W-1:0]         mem_wdata,
   input  logic [DATA_W-1:0]         mem_rdata,
   output logic [LANES-1:0]          reg_wr_en,
   output logic [REG_W-1:0]          reg_wr_idx,
   output logic [LANES*DATA_W-1:0]   reg_wr_data
);

   if (LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("lane_ls_bridge: LANES must be a power of two of at least 2");
   end
   if (ADDR_W < 1 || ADDR_W > DATA_W) begin : g_bad_addr
      $error("lane_ls_bridge: ADDR_W must lie in 1..DATA_W");
   end
   if (REG_W < 1) begin : g_bad_reg
      $error("lane_ls_bridge: REG_W must be positive");
   end

   lsb_op_e                 op;
   logic                    accept;
   logic                    fill_valid;
   logic                    fill_wide;
   logic [LANE_W-1:0]       fill_lane;
   logic [LANES*DATA_W-1:0] slots;
   logic [DATA_W-1:0]       sel_data;

   assign op     = lsb_op_e'(op_code);
   assign accept = op_valid && !busy;

   lsb_mem_port #(.LANES(LANES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_port (
      .clk(clk), .rst_n(rst_n), .accept(accept), .op(op),
      .op_lane(op_lane), .op_addr(op_addr), .lane_addr(lane_addr),
      .sel_data(sel_data), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .fill_valid(fill_valid),
      .fill_wide(fill_wide), .fill_lane(fill_lane)
   );

   lsb_slot_bank #(.LANES(LANES), .DATA_W(DATA_W), .CLEAR_SLOTS(CLEAR_SLOTS)) u_bank (
      .clk(clk), .rst_n(rst_n), .fill_valid(fill_valid), .fill_wide(fill_wide),
      .fill_lane(fill_lane), .mem_rdata(mem_rdata),
      .load_regs(accept && op == OP_FROM_REGS), .lane_rd_data(lane_rd_data),
      .rd_lane(op_lane), .slots(slots), .sel_data(sel_data)
   );

   lsb_lane_xfer #(.LANES(LANES), .DATA_W(DATA_W), .REG_W(REG_W)) u_xfer (
      .clk(clk), .rst_n(rst_n), .accept(accept), .op(op), .op_reg(op_reg),
      .slots(slots), .sel_data(sel_data), .reg_wr_en(reg_wr_en),
      .reg_wr_idx(reg_wr_idx), .reg_wr_data(reg_wr_data)
   );

   p_busy_blocks_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && busy) |=> !mem_req);
   p_fanout_equal_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !busy && op == OP_FANOUT) |=>
         (reg_wr_data[0 +: DATA_W] == reg_wr_data[(LANES-1)*DATA_W +: DATA_W]));
   p_reset_quiet_r1: assert property (@(posedge clk)
      $rose(rst_n) |-> (!busy && !mem_req && reg_wr_en == '0));

endmodule

// File: tb/lane_ls_bridge_test.sv
module lane_ls_bridge_test;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         op_valid = 1'b0;
   logic [3:0]   op_code = '0;
   logic [1:0]   op_lane = '0;
   logic [13:0]  op_addr = '0;
   logic [4:0]   op_reg = '0;
   logic [55:0]  lane_addr;
   logic [127:0] lane_rd_data;
   logic         busy, mem_req, mem_we;
   logic [13:0]  mem_addr;
   logic [31:0]  mem_wdata;
   logic [31:0]  mem_rdata = '0;
   logic [3:0]   reg_wr_en;
   logic [4:0]   reg_wr_idx;
   logic [127:0] reg_wr_data;

   int n_chk = 0;
   int n_fail = 0;
   logic [31:0] mem [64];
   logic [31:0] sh [4];

   always #5 clk = ~clk;

   for (genvar i = 0; i < 4; i++) begin : g_lane
      assign lane_addr[i*14 +: 14]    = 14'(30 + i);
      assign lane_rd_data[i*32 +: 32] = 32'hC0DE_0000 + 32'(i);
   end

   lane_ls_bridge uut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .op_lane(op_lane), .op_addr(op_addr), .op_reg(op_reg),
      .lane_addr(lane_addr), .lane_rd_data(lane_rd_data), .busy(busy),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .reg_wr_en(reg_wr_en),
      .reg_wr_idx(reg_wr_idx), .reg_wr_data(reg_wr_data)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 64; i++) mem[i] <= 32'(i * 16 + 1);
      end else if (mem_req) begin
         if (mem_we) mem[mem_addr[5:0]] <= mem_wdata;
         else        mem_rdata <= mem[mem_addr[5:0]];
      end
   end

   typedef struct packed {
      logic [3:0]  op;
      logic [1:0]  lane;
      logic [13:0] addr;
      logic [4:0]  rg;
   } vec_t;

   localparam int NV = 17;
   localparam vec_t VEC [NV] = '{
      '{4'd1, 2'd0, 14'd4,  5'd0},
      '{4'd1, 2'd1, 14'd5,  5'd0},
      '{4'd1, 2'd2, 14'd6,  5'd0},
      '{4'd1, 2'd3, 14'd7,  5'd0},
      '{4'd6, 2'd0, 14'd0,  5'd3},
      '{4'd8, 2'd2, 14'd0,  5'd9},
      '{4'd3, 2'd1, 14'd10, 5'd0},
      '{4'd6, 2'd0, 14'd0,  5'd1},
      '{4'd7, 2'd0, 14'd0,  5'd0},
      '{4'd6, 2'd0, 14'd0,  5'd2},
      '{4'd2, 2'd2, 14'd20, 5'd0},
      '{4'd1, 2'd0, 14'd20, 5'd0},
      '{4'd4, 2'd1, 14'd0,  5'd0},
      '{4'd5, 2'd3, 14'd0,  5'd0},
      '{4'd3, 2'd0, 14'd33, 5'd0},
      '{4'd6, 2'd0, 14'd0,  5'd4},
      '{4'd8, 2'd3, 14'd0,  5'd31}
   };

   task automatic chk(input string req, input string what,
                      input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [127:0] pack_sh();
      return {sh[3], sh[2], sh[1], sh[0]};
   endfunction

   function automatic string tag_of(input logic [3:0] op);
      case (op)
         4'd1: return "R3";
         4'd2: return "R4";
         4'd3: return "R5";
         4'd4, 4'd5: return "R9";
         4'd6: return "R6";
         4'd7: return "R7";
         default: return "R8";
      endcase
   endfunction

   task automatic run_op(input logic [3:0] op, input logic [1:0] lane,
                         input logic [13:0] addr, input logic [4:0] rg);
      logic        is_mem, is_rd, is_ix;
      logic [13:0] ea;
      logic [31:0] rv;
      int          cnt;
      string       t;
      t      = tag_of(op);
      is_mem = (op >= 4'd1 && op <= 4'd5);
      is_rd  = (op == 4'd1 || op == 4'd3 || op == 4'd4);
      is_ix  = (op == 4'd4 || op == 4'd5);
      ea     = is_ix ? 14'(30 + 32'(lane)) : addr;
      @(negedge clk);
      op_valid = 1'b1; op_code = op; op_lane = lane; op_addr = addr; op_reg = rg;
      @(negedge clk);
      op_valid = 1'b0;
      rv = mem[ea[5:0]];
      if (is_mem) begin
         chk("R10", "mem_req", 128'(mem_req), 128'd1);
         chk(t, "mem_addr", 128'(mem_addr), 128'(ea));
         chk("R10", "mem_we", 128'(mem_we), 128'(!is_rd));
         if (!is_rd) chk(t, "mem_wdata", 128'(mem_wdata), 128'(sh[lane]));
         cnt = 0;
         while (busy && cnt < 8) begin
            cnt++;
            @(negedge clk);
            if (cnt == 1) chk("R10", "req pulse", 128'(mem_req), 128'd0);
         end
         chk(is_rd ? "R3" : "R4", "busy cycles", 128'(cnt), is_rd ? 128'd2 : 128'd1);
         if (is_rd) begin
            rv = mem[ea[5:0]];
            if (op == 4'd3) for (int i = 0; i < 4; i++) sh[i] = rv;
            else sh[lane] = rv;
         end
      end else if (op == 4'd7) begin
         chk("R7", "busy", 128'(busy), 128'd0);
         for (int i = 0; i < 4; i++) sh[i] = 32'hC0DE_0000 + 32'(i);
      end else begin
         chk(t, "wr_en", 128'(reg_wr_en), 128'hF);
         chk(t, "wr_idx", 128'(reg_wr_idx), 128'(rg));
         chk(t, "wr_data", reg_wr_data,
             (op == 4'd6) ? pack_sh() : {4{sh[lane]}});
         @(negedge clk);
         chk("R6", "wr_en drop", 128'(reg_wr_en), 128'd0);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL R2 watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      for (int i = 0; i < 4; i++) sh[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "busy", 128'(busy), 128'd0);
      chk("R1", "mem_req", 128'(mem_req), 128'd0);
      chk("R1", "reg_wr_en", 128'(reg_wr_en), 128'd0);
      run_op(4'd6, 2'd0, 14'd0, 5'd0);   // R1: slots read back as zero

      for (int k = 0; k < NV; k++)
         run_op(VEC[k].op, VEC[k].lane, VEC[k].addr, VEC[k].rg);

      // R2: operations held during a fetch are ignored
      @(negedge clk);
      op_valid = 1'b1; op_code = 4'd1; op_lane = 2'd0; op_addr = 14'd40;
      @(negedge clk);
      op_code = 4'd7;
      chk("R2", "busy", 128'(busy), 128'd1);
      @(negedge clk);
      op_code = 4'd8; op_lane = 2'd2;
      chk("R2", "no req", 128'(mem_req), 128'd0);
      chk("R2", "no wr", 128'(reg_wr_en), 128'd0);
      @(negedge clk);
      op_valid = 1'b0;
      chk("R2", "idle", 128'(busy), 128'd0);
      chk("R2", "no wr", 128'(reg_wr_en), 128'd0);
      sh[0] = mem[40];
      run_op(4'd6, 2'd0, 14'd0, 5'd5);
      chk("R2", "slot0 fetched", 128'(sh[0]), 128'h281);
      run_op(4'd8, 2'd0, 14'd0, 5'd7);

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule